// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between the register side and the serial engine of an SPI controller. It owns the transmit and receive FIFOs. Software pushes words into the transmit FIFO and pops words from the receive FIFO. The serial engine does the reverse on the other side. From the two fill levels the block derives a five-bit status word, five interrupt sources, a single interrupt line and two level-based DMA request lines.

The interrupt sources come in two kinds. Two of them are live level comparisons: one for the transmit side and one for the receive side, where the receive rule uses a strictly-greater threshold. The other three are sticky error flags for transmit overflow, receive underflow and receive overflow. A separate clear word removes the sticky flags, and its bits are ordered differently from the interrupt vector.

While the controller is disabled, both FIFOs are held empty and the two threshold registers can be written. Once the controller is enabled, the threshold registers are frozen. Software can discover the FIFO depth by writing a value to the transmit threshold and reading it back, because the register keeps the value modulo the depth. DEPTH must be a power of two.

Top module: `spi_fifo_stat_irq`

## Requirements
- R1: After reset, both levels are 0, status is 5'b01100, the raw vector is 5'b00001, the masked vector is 0, irq is 0 and both DMA requests are 0.
- R2: With `en` high, a `tx_wr` to a non-full TX FIFO adds one word, and the engine sees words on `eng_tx_data` in write order. An `eng_rx_push` to a non-full RX FIFO adds one word, and software reads words on `rx_rdata` in push order. Each level counts the stored words.
- R3: The status bits are: bit 0 busy = `en` & (`eng_busy` | TX not empty); bit 1 = TX full; bit 2 = TX empty; bit 3 = RX empty; bit 4 = RX full.
- R4: A `tx_wr` while the TX FIFO holds DEPTH words is dropped. It sets the sticky TX-overflow flag at raw bit 1.
- R5: An `rx_rd` while the RX FIFO is empty sets the sticky RX-underflow flag at raw bit 2. An `eng_rx_push` into a full RX FIFO is dropped and sets the sticky RX-overflow flag at raw bit 3.
- R6: Raw bit 0 is 1 while the TX level is at or below the TX threshold. Raw bit 4 is 1 only while the RX level is strictly greater than the RX threshold.
- R7: A `wr_iclr` pulse uses `cfg_wdata` as follows: bit 0 clears all three sticky flags, bit 1 clears RX underflow, bit 2 clears RX overflow, bit 3 clears TX overflow. A flag event in the same cycle as its clear leaves the flag set.
- R8: `wr_imask` loads the mask from `cfg_wdata[4:0]`. `int_masked` is raw AND mask, and `irq` is the OR of `int_masked`.
- R9: `wr_tx_thr` and `wr_rx_thr` take effect only while `en` is low, and they are ignored while it is high. The stored value is `cfg_wdata` modulo DEPTH, read back zero-extended on `tx_thr_rd` and `rx_thr_rd`, so a write of DEPTH reads back 0.
- R10: `wr_dmactl` loads the DMA enables: bit 0 enables RX, bit 1 enables TX. `wr_tx_dlvl` and `wr_rx_dlvl` load the DMA levels from the low level-width bits at any time. `tx_dma_req` = `en` & TX enable & (TX level <= TX DMA level). `rx_dma_req` = `en` & RX enable & (RX level > RX DMA level).
- R11: While `en` is low, both FIFOs are emptied and every FIFO access is ignored without setting any flag. Sticky flags and configuration are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable |
| eng_busy | input | 1 | Serial engine is shifting |
| tx_wr | input | 1 | Software write to the TX FIFO |
| tx_wdata | input | DW | TX write word |
| rx_rd | input | 1 | Software read from the RX FIFO |
| rx_rdata | output | DW | RX FIFO head word |
| eng_tx_pop | input | 1 | Engine takes the TX head |
| eng_tx_data | output | DW | TX FIFO head word |
| eng_rx_push | input | 1 | Engine stores a received word |
| eng_rx_data | input | DW | Received word |
| wr_tx_thr | input | 1 | Write the TX threshold |
| wr_rx_thr | input | 1 | Write the RX threshold |
| wr_tx_dlvl | input | 1 | Write the TX DMA level |
| wr_rx_dlvl | input | 1 | Write the RX DMA level |
| wr_dmactl | input | 1 | Write the DMA enables |
| wr_imask | input | 1 | Write the interrupt mask |
| wr_iclr | input | 1 | Clear strobe for the sticky flags |
| cfg_wdata | input | CW | Configuration write word |
| tx_thr_rd | output | CW | TX threshold readback |
| rx_thr_rd | output | CW | RX threshold readback |
| tx_level | output | LW | TX FIFO level |
| rx_level | output | LW | RX FIFO level |
| status | output | 5 | Status word |
| int_raw | output | 5 | Raw interrupt vector |
| int_masked | output | 5 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
Every stored quantity changes on the rising edge that samples its strobe: levels, sticky flags, thresholds, DMA levels, enables and mask. Status, the raw and masked vectors, irq and the DMA requests are combinational views of that state, and `en` reaches them in the same cycle. The FIFO heads are visible on `rx_rdata` and `eng_tx_data` without delay. The bench therefore drives a stimulus after a falling edge and releases it at the next falling edge. It compares every output there against its own arithmetic model, once exactly one rising edge has been taken. It reads the head data before issuing a pop.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  // interrupt vector positions (raw, mask, masked)
  localparam int IR_TXLOW = 0;
  localparam int IR_TXOVF = 1;
  localparam int IR_RXUNF = 2;
  localparam int IR_RXOVF = 3;
  localparam int IR_RXHI  = 4;
  // status positions
  localparam int ST_BUSY    = 0;
  localparam int ST_TXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_RXEMPTY = 3;
  localparam int ST_RXFULL  = 4;
  // clear word positions
  localparam int CL_ALL   = 0;
  localparam int CL_RXUNF = 1;
  localparam int CL_RXOVF = 2;
  localparam int CL_TXOVF = 3;
  // DMA enable positions
  localparam int DE_RX = 0;
  localparam int DE_TX = 1;

  function automatic logic lvl_at_or_below(input logic [15:0] lvl, input logic [15:0] lim);
    return lvl <= lim;
  endfunction

  function automatic logic lvl_above(input logic [15:0] lvl, input logic [15:0] lim);
    return lvl > lim;
  endfunction

  // returns clear bits in sticky order {rxovf, rxunf, txovf}
  function automatic logic [2:0] clr_decode(input logic [3:0] c);
    return {c[CL_ALL] | c[CL_RXOVF], c[CL_ALL] | c[CL_RXUNF], c[CL_ALL] | c[CL_TXOVF]};
  endfunction
endpackage

// File: rtl/spi_sfifo.sv
module spi_sfifo #(
  parameter int DW = 16,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_tx_thr,
  input  logic          wr_rx_thr,
  input  logic          wr_tx_dlvl,
  input  logic          wr_rx_dlvl,
  input  logic          wr_dmactl,
  input  logic [LW-1:0] wdata,
  output logic [AW-1:0] tx_thr,
  output logic [AW-1:0] rx_thr,
  output logic [LW-1:0] tx_dlvl,
  output logic [LW-1:0] rx_dlvl,
  output logic [1:0]    dma_en
);
  // threshold writes are accepted only while the controller is idle
  logic thr_open;
  assign thr_open = ~en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr  <= '0;
      rx_thr  <= '0;
      tx_dlvl <= '0;
      rx_dlvl <= '0;
      dma_en  <= '0;
    end else begin
      if (wr_tx_thr && thr_open) tx_thr <= wdata[AW-1:0];
      if (wr_rx_thr && thr_open) rx_thr <= wdata[AW-1:0];
      if (wr_tx_dlvl) tx_dlvl <= wdata;
      if (wr_rx_dlvl) rx_dlvl <= wdata;
      if (wr_dmactl)  dma_en  <= wdata[1:0];
    end
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_ovf_evt,
  input  logic       rx_unf_evt,
  input  logic       rx_ovf_evt,
  input  logic       tx_low,
  input  logic       rx_high,
  input  logic       iclr_wr,
  input  logic [3:0] iclr_bits,
  input  logic       imask_wr,
  input  logic [4:0] imask_bits,
  output logic [4:0] raw,
  output logic [4:0] masked,
  output logic       irq
);
  logic [2:0] flg_q;   // {rxovf, rxunf, txovf}
  logic [2:0] flg_clr, flg_set;
  logic [4:0] mask_q;

  assign flg_clr = iclr_wr ? clr_decode(iclr_bits) : 3'b000;
  assign flg_set = {rx_ovf_evt, rx_unf_evt, tx_ovf_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q  <= '0;
      mask_q <= '0;
    end else begin
      flg_q <= (flg_q & ~flg_clr) | flg_set;   // a new event outranks its clear
      if (imask_wr) mask_q <= imask_bits;
    end
  end

  always_comb begin
    raw           = '0;
    raw[IR_TXLOW] = tx_low;
    raw[IR_TXOVF] = flg_q[0];
    raw[IR_RXUNF] = flg_q[1];
    raw[IR_RXOVF] = flg_q[2];
    raw[IR_RXHI]  = rx_high;
  end

  assign masked = raw & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/spi_fifo_stat_irq.sv
module spi_fifo_stat_irq
  import spi_fifo_pkg::*;
#(
  parameter int DW = 16,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = (LW > 5) ? LW : 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          eng_busy,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          wr_tx_thr,
  input  logic          wr_rx_thr,
  input  logic          wr_tx_dlvl,
  input  logic          wr_rx_dlvl,
  input  logic          wr_dmactl,
  input  logic          wr_imask,
  input  logic          wr_iclr,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] tx_thr_rd,
  output logic [CW-1:0] rx_thr_rd,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic [4:0]    status,
  output logic [4:0]    int_raw,
  output logic [4:0]    int_masked,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  logic          flush;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_ovf_evt, rx_unf_evt, rx_ovf_evt;
  logic          tx_low, rx_high;
  logic [AW-1:0] tx_thr, rx_thr;
  logic [LW-1:0] tx_dlvl, rx_dlvl;
  logic [1:0]    dma_en;

  assign flush = ~en;

  // named error events: dropped accesses while enabled
  assign tx_ovf_evt = en & tx_wr & tx_full;
  assign rx_unf_evt = en & rx_rd & rx_empty;
  assign rx_ovf_evt = en & eng_rx_push & rx_full;

  spi_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_wr), .wdata(tx_wdata), .pop(eng_tx_pop),
    .rdata(eng_tx_data), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spi_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(eng_rx_push), .wdata(eng_rx_data), .pop(rx_rd),
    .rdata(rx_rdata), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  spi_cfg_regs #(.DEPTH(DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wr_tx_thr(wr_tx_thr), .wr_rx_thr(wr_rx_thr),
    .wr_tx_dlvl(wr_tx_dlvl), .wr_rx_dlvl(wr_rx_dlvl), .wr_dmactl(wr_dmactl),
    .wdata(cfg_wdata[LW-1:0]),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_dlvl(tx_dlvl), .rx_dlvl(rx_dlvl),
    .dma_en(dma_en)
  );

  assign tx_low  = lvl_at_or_below(16'(tx_level), 16'(tx_thr));
  assign rx_high = lvl_above(16'(rx_level), 16'(rx_thr));

  spi_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_ovf_evt(tx_ovf_evt), .rx_unf_evt(rx_unf_evt), .rx_ovf_evt(rx_ovf_evt),
    .tx_low(tx_low), .rx_high(rx_high),
    .iclr_wr(wr_iclr), .iclr_bits(cfg_wdata[3:0]),
    .imask_wr(wr_imask), .imask_bits(cfg_wdata[4:0]),
    .raw(int_raw), .masked(int_masked), .irq(irq)
  );

  assign tx_thr_rd = CW'(tx_thr);
  assign rx_thr_rd = CW'(rx_thr);

  always_comb begin
    status             = '0;
    status[ST_BUSY]    = en & (eng_busy | ~tx_empty);
    status[ST_TXFULL]  = tx_full;
    status[ST_TXEMPTY] = tx_empty;
    status[ST_RXEMPTY] = rx_empty;
    status[ST_RXFULL]  = rx_full;
  end

  assign tx_dma_req = en & dma_en[DE_TX] & lvl_at_or_below(16'(tx_level), 16'(tx_dlvl));
  assign rx_dma_req = en & dma_en[DE_RX] & lvl_above(16'(rx_level), 16'(rx_dlvl));
endmodule

// File: rtl/spi_fifo_stat_irq_chk.sv
module spi_fifo_stat_irq_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = (LW > 5) ? LW : 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          tx_wr,
  input logic          rx_rd,
  input logic          eng_tx_pop,
  input logic          wr_iclr,
  input logic [CW-1:0] cfg_wdata,
  input logic [CW-1:0] tx_thr_rd,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic [4:0]    status,
  input logic [4:0]    int_raw,
  input logic          tx_dma_req,
  input logic          rx_dma_req
);
  // R4: a dropped write to a full TX FIFO leaves the level at DEPTH
  a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    en && tx_wr && !eng_tx_pop && tx_level == LW'(DEPTH) |=> tx_level == LW'(DEPTH));

  // R4/R7: TX overflow flag stays until a clear word names it
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    int_raw[1] && !(wr_iclr && (cfg_wdata[0] || cfg_wdata[3])) |=> int_raw[1]);

  // R5: reading an empty RX FIFO raises the underflow flag
  a_r5_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
    en && rx_rd && rx_level == '0 |=> int_raw[2]);

  // R3: full and empty never coincide on either side
  a_r3_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[2]) && !(status[3] && status[4]));

  // R9: thresholds do not move while enabled
  a_r9_thr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(tx_thr_rd));

  // R10: no DMA request while disabled
  a_r10_dma_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_dma_req && !rx_dma_req);

  // R11: disabling empties both FIFOs
  a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> tx_level == '0 && rx_level == '0);

  // R2: levels never exceed the depth
  a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH));
endmodule

bind spi_fifo_stat_irq spi_fifo_stat_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_wr(tx_wr), .rx_rd(rx_rd),
  .eng_tx_pop(eng_tx_pop), .wr_iclr(wr_iclr), .cfg_wdata(cfg_wdata),
  .tx_thr_rd(tx_thr_rd), .tx_level(tx_level), .rx_level(rx_level),
  .status(status), .int_raw(int_raw), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
);

// File: tb/spi_fifo_stat_irq_tb.sv
module spi_fifo_stat_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 8;
  localparam int DW = 16;
  localparam int LW = 4;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0, en = 0, eng_busy = 0;
  logic tx_wr = 0, rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [DW-1:0] tx_wdata = 0, eng_rx_data = 0, rx_rdata, eng_tx_data;
  logic wr_tx_thr = 0, wr_rx_thr = 0, wr_tx_dlvl = 0, wr_rx_dlvl = 0;
  logic wr_dmactl = 0, wr_imask = 0, wr_iclr = 0;
  logic [CW-1:0] cfg_wdata = 0, tx_thr_rd, rx_thr_rd;
  logic [LW-1:0] tx_level, rx_level;
  logic [4:0] status, int_raw, int_masked;
  logic irq, tx_dma_req, rx_dma_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_stat_irq #(.DW(DW), .DEPTH(D)) u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  int m_txl = 0, m_rxl = 0, m_txh = 0, m_rxh = 0;
  int m_tq [D];
  int m_rq [D];
  bit m_txo = 0, m_rxu = 0, m_rxo = 0;
  int m_txthr = 0, m_rxthr = 0, m_txd = 0, m_rxd = 0, m_de = 0, m_mask = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_status();
    return ((m_rxl == D) << 4) | ((m_rxl == 0) << 3) | ((m_txl == 0) << 2) |
           ((m_txl == D) << 1) | int'(en && (eng_busy || m_txl != 0));
  endfunction

  function automatic int exp_raw();
    return ((m_rxl > m_rxthr) << 4) | (int'(m_rxo) << 3) | (int'(m_rxu) << 2) |
           (int'(m_txo) << 1) | int'(m_txl <= m_txthr);
  endfunction

  task automatic check_all(input string req);
    int mk;
    mk = exp_raw() & m_mask;
    chk(req, "tx_level", int'(tx_level), m_txl);
    chk(req, "rx_level", int'(rx_level), m_rxl);
    chk(req, "status", int'(status), exp_status());
    chk(req, "int_raw", int'(int_raw), exp_raw());
    chk(req, "int_masked", int'(int_masked), mk);
    chk(req, "irq", int'(irq), int'(mk != 0));
    chk(req, "tx_dma_req", int'(tx_dma_req), int'(en && m_de[1] && m_txl <= m_txd));
    chk(req, "rx_dma_req", int'(rx_dma_req), int'(en && m_de[0] && m_rxl > m_rxd));
    chk(req, "tx_thr_rd", int'(tx_thr_rd), m_txthr);
    chk(req, "rx_thr_rd", int'(rx_thr_rd), m_rxthr);
  endtask

  task automatic model_step();
    int c;
    c = int'(cfg_wdata);
    if (wr_iclr) begin
      if (c[0] || c[3]) m_txo = 0;
      if (c[0] || c[1]) m_rxu = 0;
      if (c[0] || c[2]) m_rxo = 0;
    end
    if (!en) begin
      m_txl = 0; m_rxl = 0; m_txh = 0; m_rxh = 0;
    end else begin
      if (tx_wr) begin
        if (m_txl == D) m_txo = 1;
        else begin m_tq[(m_txh + m_txl) % D] = int'(tx_wdata); m_txl++; end
      end
      if (eng_tx_pop && m_txl > 0 && !(tx_wr && m_txl == D)) begin
        m_txh = (m_txh + 1) % D; m_txl--;
      end else if (eng_tx_pop && m_txl > 0) begin
        m_txh = (m_txh + 1) % D; m_txl--;
      end
      if (eng_rx_push) begin
        if (m_rxl == D) m_rxo = 1;
        else begin m_rq[(m_rxh + m_rxl) % D] = int'(eng_rx_data); m_rxl++; end
      end
      if (rx_rd) begin
        if (m_rxl == 0) m_rxu = 1;
        else begin m_rxh = (m_rxh + 1) % D; m_rxl--; end
      end
    end
    if (wr_tx_thr && !en) m_txthr = c % D;
    if (wr_rx_thr && !en) m_rxthr = c % D;
    if (wr_tx_dlvl) m_txd = c % 16;
    if (wr_rx_dlvl) m_rxd = c % 16;
    if (wr_dmactl) m_de = c % 4;
    if (wr_imask) m_mask = c % 32;
  endtask

  task automatic clk1();
    model_step();
    @(negedge clk);
    tx_wr = 0; rx_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
    wr_tx_thr = 0; wr_rx_thr = 0; wr_tx_dlvl = 0; wr_rx_dlvl = 0;
    wr_dmactl = 0; wr_imask = 0; wr_iclr = 0;
  endtask

  task automatic cfg(input int sel, input int v);
    cfg_wdata = CW'(v);
    case (sel)
      0: wr_tx_thr = 1;
      1: wr_rx_thr = 1;
      2: wr_tx_dlvl = 1;
      3: wr_rx_dlvl = 1;
      4: wr_dmactl = 1;
      5: wr_imask = 1;
      default: wr_iclr = 1;
    endcase
    clk1();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all actual=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "status", int'(status), 5'b01100);
    chk("R1", "int_raw", int'(int_raw), 5'b00001);
    check_all("R1");

    // R9 depth discovery and threshold writes while idle
    cfg(0, D);   check_all("R9");
    chk("R9", "tx_thr wraps", int'(tx_thr_rd), 0);
    cfg(0, 3);   cfg(1, 2);
    chk("R9", "tx_thr", int'(tx_thr_rd), 3);
    cfg(5, 5'h1f); cfg(4, 3); cfg(2, 2); cfg(3, 5);
    check_all("R10");

    // R2 R4 R6: fill TX past full
    en = 1;
    @(negedge clk); check_all("R3");
    for (int i = 0; i < D + 2; i++) begin
      tx_wr = 1; tx_wdata = DW'(16'hA000 + i); clk1(); check_all("R4");
    end
    chk("R4", "tx ovf flag", int'(int_raw[1]), 1);
    // R9 ignored while enabled
    cfg(0, 6); check_all("R9");
    // R2 engine drains TX in order
    for (int i = 0; i < D; i++) begin
      chk("R2", "eng_tx_data", int'(eng_tx_data), m_tq[m_txh]);
      eng_tx_pop = 1; clk1(); check_all("R2");
    end
    // R7 clear TX overflow via bit 3
    cfg(6, 4'b1000); check_all("R7");

    // R5: RX overflow then underflow
    for (int i = 0; i < D + 1; i++) begin
      eng_rx_push = 1; eng_rx_data = DW'(16'hB000 + 3 * i); clk1(); check_all("R5");
    end
    for (int i = 0; i < D + 1; i++) begin
      if (m_rxl > 0) chk("R2", "rx_rdata", int'(rx_rdata), m_rq[m_rxh]);
      rx_rd = 1; clk1(); check_all("R5");
    end
    chk("R5", "rx flags", int'(int_raw[3:2]), 2'b11);
    cfg(6, 4'b0010); check_all("R7");
    chk("R7", "rxovf kept", int'(int_raw[3:2]), 2'b10);
    cfg(6, 4'b0001); check_all("R7");

    // R7 set wins over clear in the same cycle
    for (int i = 0; i < D; i++) begin tx_wr = 1; tx_wdata = DW'(i); clk1(); end
    tx_wr = 1; wr_iclr = 1; cfg_wdata = 5'b00001; clk1(); check_all("R7");
    chk("R7", "set beats clear", int'(int_raw[1]), 1);

    // R3 busy from the engine
    eng_busy = 1; @(negedge clk); check_all("R3");
    eng_busy = 0;

    // R11 disable flushes, keeps flags, ignores accesses
    en = 0; clk1(); check_all("R11");
    tx_wr = 1; rx_rd = 1; eng_rx_push = 1; clk1(); check_all("R11");
    chk("R11", "flag kept", int'(int_raw[1]), 1);
    cfg(6, 1);

    // R6 R10 sweep of thresholds and DMA levels over all fill levels
    for (int t = 0; t < D; t++) begin
      cfg_wdata = CW'(t);
      wr_tx_thr = 1; wr_rx_thr = 1; wr_tx_dlvl = 1; wr_rx_dlvl = 1;
      clk1(); check_all("R9");
      en = 1;
      for (int i = 0; i < D; i++) begin
        tx_wr = 1; eng_rx_push = 1; tx_wdata = DW'(i); eng_rx_data = DW'(i);
        clk1(); check_all("R6");
      end
      en = 0; clk1(); check_all("R11");
    end

    // R8 mask sweep with a mixed raw vector
    en = 1; cfg(1, 0);
    cfg(0, 0);
    eng_rx_push = 1; clk1(); rx_rd = 1; clk1(); rx_rd = 1; clk1();
    for (int m = 0; m < 32; m++) begin cfg(5, m); check_all("R8"); end
    cfg(4, 0); check_all("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule